// File: doc/BRIEF.md
# Broadcast-Sample Convolver with Rotating Tagged Coefficients

This block computes a finite convolution of an incoming sample stream with a set of `TAPS` signed coefficients. Every accepted sample goes to all cells in the same cycle. The coefficients travel around a ring of cells, one position per accepted sample, and wrap from the last cell back to the first. Each cell keeps its own running sum in a wide local accumulator. The sums stay in place while the coefficients move past them.

One coefficient carries a marker bit. When a cell holds the marked coefficient, its accumulator contains a finished window. That cell places the window on a shared result bus and starts its next window with the current product. Only the cell holding the marker drives the bus, so the bus needs no arbitration logic. Coefficients are loaded serially through a shift-in port. Loading restarts the computation from a zero history.

The result for the window that ends with sample n leaves the block when sample n+1 is accepted. Results therefore trail the stream by one sample.

Top module: `bcast_conv`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `res_valid` is 0 and `res_data` is 0.
- R2: Each cycle with `wl_valid` high shifts `wl_data` into the coefficient ring. The coefficients are written with the highest index first, so after `TAPS` writes the last value written is w[0]. Every load cycle clears all accumulators and restarts the sample count. A sample presented in a load cycle is ignored.
- R3: Counting accepted samples from 0 after the last load, the result produced by sample t (t >= 1) equals y(t-1) = sum over k of w[k]*x[t-1-k]. The sum is signed, and samples before the load count as zero.
- R4: The first accepted sample after a load produces no result.
- R5: `res_valid` is high exactly in the cycle after each accepted sample other than the first after a load, and low otherwise. Idle cycles between samples leave the accumulators and the coefficient positions unchanged.
- R6: The coefficients keep circulating indefinitely. Streams much longer than `TAPS` keep producing correct results, and after each accepted sample cell 0 holds the coefficient that the last cell held before.
- R7: Accumulators are DW+WW+clog2(TAPS) bits wide. Full-scale windows, including every product at (-2^(DW-1))*(-2^(WW-1)), come out exact.
- R8: Exactly one cell holds the marker at all times. The bus value comes only from that cell's accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wl_valid | input | 1 | Coefficient load strobe; shifts `wl_data` into the ring |
| wl_data | input | WW | Signed coefficient, highest index first |
| smp_valid | input | 1 | Sample strobe (ignored while `wl_valid` is high) |
| smp_data | input | DW | Signed sample, broadcast to every cell |
| res_valid | output | 1 | Result strobe, registered |
| res_data | output | DW+WW+clog2(TAPS) | Signed convolution result, registered |

## Verification
The hardest situation to reach from the ports is a load that arrives after the accumulators already hold partial windows and the marker has moved away from its home cell, with a sample collision in the same cycles. The bench streams samples first so that the marker rotates. It then reloads while holding the sample strobe high with a value that must be ignored. After that it checks that the next results match a model whose history restarts from zero. Gaps in the sample strobe and full-scale negative operands are driven separately, so that hold behaviour and accumulator width are each exercised on their own.

// File: rtl/conv_pkg.sv
package conv_pkg;
  // accumulator width: full product plus growth over TAPS terms
  function automatic int acc_bits(int dw, int ww, int taps);
    return dw + ww + $clog2(taps);
  endfunction
endpackage

// File: rtl/conv_cell.sv
module conv_cell #(
  parameter int DW   = 8,
  parameter int WW   = 8,
  parameter int AW   = 18,
  parameter bit LAST = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic          step,
  input  logic [DW-1:0] smp,
  input  logic [WW-1:0] w_in,
  input  logic          tag_in,
  output logic [WW-1:0] w_q,
  output logic          tag_q,
  output logic [AW-1:0] acc_q
);
  logic signed [AW-1:0] prod;
  assign prod = AW'($signed(smp)) * AW'($signed(w_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q   <= '0;
      tag_q <= LAST;
      acc_q <= '0;
    end else if (ld) begin
      w_q   <= w_in;
      tag_q <= LAST;
      acc_q <= '0;
    end else if (step) begin
      w_q   <= w_in;
      tag_q <= tag_in;
      acc_q <= tag_q ? prod : acc_q + prod;
    end
  end

  // R2
  acc_clear_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> acc_q == '0);
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ld && !step) |=> ($stable(acc_q) && $stable(w_q) && $stable(tag_q)));
endmodule

// File: rtl/conv_collect.sv
module conv_collect #(
  parameter int TAPS = 4,
  parameter int AW   = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ld,
  input  logic                     step,
  input  logic [TAPS-1:0]          tags,
  input  logic [TAPS-1:0][AW-1:0]  accs,
  output logic                     res_valid,
  output logic [AW-1:0]            res_data
);
  logic          primed;
  logic [AW-1:0] pick;

  // one-hot marker acts as the bus grant
  always_comb begin
    pick = '0;
    for (int c = 0; c < TAPS; c++)
      if (tags[c]) pick = pick | accs[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed    <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= step & primed;
      if (step) res_data <= pick;
      if (ld)        primed <= 1'b0;
      else if (step) primed <= 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!res_valid && res_data == '0));
  // R5
  valid_follows_sample_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(step));
  // R4
  first_after_load_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (ld && !step) |=> ##1 (!res_valid));
endmodule

// File: rtl/bcast_conv.sv
module bcast_conv #(
  parameter  int TAPS = 4,
  parameter  int DW   = 8,
  parameter  int WW   = 8,
  localparam int AW   = conv_pkg::acc_bits(DW, WW, TAPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wl_valid,
  input  logic [WW-1:0] wl_data,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  output logic          res_valid,
  output logic [AW-1:0] res_data
);
  logic ld, step;
  assign ld   = wl_valid;
  assign step = smp_valid & ~wl_valid;

  logic [WW-1:0]           w_q [TAPS];
  logic [TAPS-1:0]         tag_q;
  logic [TAPS-1:0][AW-1:0] acc_q;

  for (genvar c = 0; c < TAPS; c++) begin : g_cell
    logic [WW-1:0] w_src;
    logic          t_src;
    if (c == 0) begin : g_head
      assign w_src = ld ? wl_data : w_q[TAPS-1];
      assign t_src = tag_q[TAPS-1];
    end else begin : g_body
      assign w_src = w_q[c-1];
      assign t_src = tag_q[c-1];
    end
    conv_cell #(.DW(DW), .WW(WW), .AW(AW), .LAST(c == TAPS-1)) u_cell (
      .clk(clk), .rst(rst), .ld(ld), .step(step), .smp(smp_data),
      .w_in(w_src), .tag_in(t_src),
      .w_q(w_q[c]), .tag_q(tag_q[c]), .acc_q(acc_q[c])
    );
  end

  conv_collect #(.TAPS(TAPS), .AW(AW)) u_collect (
    .clk(clk), .rst(rst), .ld(ld), .step(step),
    .tags(tag_q), .accs(acc_q),
    .res_valid(res_valid), .res_data(res_data)
  );

  // R8
  single_marker_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(tag_q));
  // R6
  ring_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> w_q[0] == $past(w_q[TAPS-1]));
endmodule

// File: tb/bcast_conv_bench.sv
`timescale 1ns/1ps
module bcast_conv_bench;
  localparam int TAPS = 4;
  localparam int DW   = 8;
  localparam int WW   = 8;
  localparam int AW   = conv_pkg::acc_bits(DW, WW, TAPS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wl_valid = 1'b0;
  logic [WW-1:0] wl_data = '0;
  logic          smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic          res_valid;
  logic [AW-1:0] res_data;

  always #2 clk = ~clk;

  bcast_conv #(.TAPS(TAPS), .DW(DW), .WW(WW)) u_bcast_conv (
    .clk(clk), .rst(rst), .wl_valid(wl_valid), .wl_data(wl_data),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .res_valid(res_valid), .res_data(res_data)
  );

  int     total = 0;
  int     bad   = 0;
  string  cur_req = "R3";
  int     wm [TAPS];
  int     hist [$];
  longint exp_q [$];
  int     nsmp = 0;

  function automatic longint y_of(int n);
    longint s = 0;
    for (int k = 0; k < TAPS; k++)
      if (n - k >= 0) s += longint'(wm[k]) * longint'(hist[n-k]);
    return s;
  endfunction

  task automatic check(input string req, input longint got, input longint want);
    total++;
    if (got != want) begin
      bad++;
      $display("FAIL %s got=%0d expected=%0d", req, got, want);
    end
  endtask

  task automatic load_w(input int w [TAPS], input bit collide);
    for (int i = TAPS-1; i >= 0; i--) begin
      @(negedge clk);
      wl_valid  = 1'b1;
      wl_data   = WW'(w[i]);
      smp_valid = collide;
      smp_data  = DW'(77);
    end
    wm = w;
    hist.delete();
    nsmp = 0;
    @(negedge clk);
    wl_valid  = 1'b0;
    smp_valid = 1'b0;
  endtask

  task automatic send(input int x);
    @(negedge clk);
    wl_valid  = 1'b0;
    smp_valid = 1'b1;
    smp_data  = DW'(x);
    hist.push_back(x);
    if (nsmp >= 1) exp_q.push_back(y_of(nsmp - 1));
    nsmp++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
      wl_valid  = 1'b0;
    end
  endtask

  // monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        check({cur_req, "/R4/R5 unexpected result"}, longint'($signed(res_data)), 0);
        bad += (longint'($signed(res_data)) == 0) ? 1 : 0;
      end else begin
        check(cur_req, longint'($signed(res_data)), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int wa [TAPS];
    int wb [TAPS];
    int wc [TAPS];
    wa = '{3, -2, 5, 1};
    wb = '{-7, 4, 0, 2};
    wc = '{-128, -128, -128, -128};

    repeat (3) @(negedge clk);
    // R1: quiet during and right after reset
    check("R1 valid in reset", res_valid, 0);
    check("R1 data in reset", res_data, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", res_valid, 0);
    check("R1 data after reset", res_data, 0);

    // R4: first sample after load yields nothing
    load_w(wa, 1'b0);
    cur_req = "R4";
    send(9);
    idle(1);
    check("R4 no result for first sample", res_valid, 0);

    // R3: back-to-back stream, mixed signs
    cur_req = "R3";
    send(-4); send(6); send(0); send(-11); send(100); send(-100); send(2);
    idle(2);

    // R5: gaps between samples
    cur_req = "R5";
    send(13); idle(3); send(-9); idle(1); send(1); idle(5); send(-1);
    idle(2);
    check("R5 nothing pending after gaps", exp_q.size(), 0);

    // R2: reload mid-stream with colliding samples, history restarts
    cur_req = "R2";
    load_w(wb, 1'b1);
    send(5);
    idle(1);
    check("R2/R4 no result after reload", res_valid, 0);
    send(-3); send(8); send(12); send(-6); send(7);
    idle(2);

    // R6: long stream, many rotations
    cur_req = "R6";
    for (int i = 0; i < 40; i++) send((i * 37) % 201 - 100);
    idle(2);

    // R7 / R8: full-scale operands, single emitting cell
    cur_req = "R7";
    load_w(wc, 1'b0);
    for (int i = 0; i < 8; i++) send(-128);
    for (int i = 0; i < 6; i++) send(127);
    idle(2);
    cur_req = "R8";
    send(-128); send(1); send(-128); send(1); send(0);
    idle(3);
    check("R5 scoreboard drained", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule